// File: doc/BRIEF.md
# Unary Inheritance Tracking Unit

This unit sits in the path between an event-capture stream and the software that keeps per-location metadata. Its input is a stream of data-movement events. For each architectural register it records the one memory location whose metadata the register currently copies. Using that record, it either drops the event or rewrites it, so that fewer metadata-update events reach the software.

A load into a register is only noted in a table. A later store of that register becomes one memory-to-memory event that names the original source address. A register operation that takes a memory operand has two sources, which the table cannot hold. Before that event the unit therefore delivers the deferred load. A write to memory that a register still inherits from is a conflict: the unit first delivers a load event for each affected register, then the write. A software-controlled enable switches all of this off, and every event then passes through unchanged. The meaning of the metadata stays entirely in software.

Top module: `inherit_track`

## Requirements
- R1: Event kind encoding on `in_kind_i`/`out_kind_o` is 0 other, 1 memory-to-register load, 2 register-to-memory store, 3 immediate-to-memory store, 4 register-op-memory, 5 memory-to-memory (output only). After reset the output is not valid, `in_ready_o` is high and no register holds an inheritance.
- R2: With tracking on, an accepted load records that register `in_reg_i` inherits from `in_addr_i` and produces no output event.
- R3: With tracking on, a store from a register that holds an inheritance is delivered as kind 5, with `out_reg_o` set to the register, `out_addr_o` the store address and `out_src_o` the recorded source. A store from a register with no inheritance is delivered unchanged. The store itself does not change that register's entry.
- R4: With tracking on, a register-op-memory on a register that holds an inheritance is preceded by a kind 1 event for that register, with `out_addr_o` set to the recorded source. The register's entry is then cleared. Without an entry, only the original event is delivered.
- R5: With tracking on, an immediate store is delivered unchanged, after any conflict events from R6.
- R6: With tracking on, a store of kind 2 or 3 whose address equals the recorded source of some other register first emits one kind 1 event per such register, in ascending register index, each carrying that source. Those entries are then cleared. The storing register itself is never counted as a conflict.
- R7: With tracking off, every accepted event, loads included, is delivered unchanged with `out_src_o` zero. While tracking is off, all entries are emptied.
- R8: Events of kind 0 or any unlisted kind pass through unchanged and leave the table as it is.
- R9: `in_ready_o` stays low while extra events for an accepted input are still to be emitted. While `out_valid_o` is high and `out_ready_i` is low, the output event is held stable.
- R10: A load into a register that already holds an inheritance replaces the recorded source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| track_en_i | input | 1 | Enables inheritance tracking |
| in_valid_i | input | 1 | Input event valid |
| in_ready_o | output | 1 | Unit can accept an input event |
| in_kind_i | input | 3 | Input event kind |
| in_reg_i | input | RW | Register index of the input event |
| in_addr_i | input | AW | Memory address of the input event |
| out_valid_o | output | 1 | Output event valid |
| out_ready_i | input | 1 | Consumer accepts the output event |
| out_kind_o | output | 3 | Output event kind |
| out_reg_o | output | RW | Register index of the output event |
| out_addr_o | output | AW | Destination or load address of the output event |
| out_src_o | output | AW | Source address of a memory-to-memory event, else zero |

## Verification
The hardest case to reach is a multi-register conflict that is emitted while the consumer applies backpressure. It needs several registers loaded from the same address, then a store to that address from a different register, and then the flush sequence has to stall with the next input already waiting. The stimulus loads three registers from one address and stores to it. It then runs a long phase of random events over a three-address pool with a random output-ready, so that conflicts, register-op flushes and stalls overlap repeatedly.

// File: rtl/inherit_track_pkg.sv
package inherit_track_pkg;
  typedef enum logic [2:0] {
    EV_OTHER = 3'd0,
    EV_LD    = 3'd1,
    EV_ST    = 3'd2,
    EV_IMM   = 3'd3,
    EV_OPM   = 3'd4,
    EV_MM    = 3'd5
  } ev_kind_e;
endpackage

// File: rtl/uit_pick_low.sv
module uit_pick_low #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
    any_o = |mask_i;
  end
endmodule

// File: rtl/uit_table.sv
module uit_table #(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 32,
  localparam int unsigned RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_all_i,
  input  logic [NREG-1:0]           clr_mask_i,
  input  logic                      set_i,
  input  logic [RW-1:0]             set_idx_i,
  input  logic [AW-1:0]             set_addr_i,
  input  logic [AW-1:0]             probe_addr_i,
  output logic [NREG-1:0]           vld_o,
  output logic [NREG-1:0][AW-1:0]   src_o,
  output logic [NREG-1:0]           hit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic set_here;
    assign set_here = set_i && (set_idx_i == RW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[g] <= 1'b0;
        src_o[g] <= '0;
      end else if (clr_all_i) begin
        vld_o[g] <= 1'b0;
      end else if (set_here) begin
        vld_o[g] <= 1'b1;
        src_o[g] <= set_addr_i;
      end else if (clr_mask_i[g]) begin
        vld_o[g] <= 1'b0;
      end
    end

    assign hit_o[g] = vld_o[g] && (src_o[g] == probe_addr_i);
  end

  // R10: a load always leaves the newest source in its entry
  a_r10_set_latest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && !clr_all_i |=> vld_o[$past(set_idx_i)] && src_o[$past(set_idx_i)] == $past(set_addr_i));
endmodule

// File: rtl/inherit_track.sv
module inherit_track
  import inherit_track_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned AW   = 32,
  localparam int unsigned RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          track_en_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2:0]    in_kind_i,
  input  logic [RW-1:0] in_reg_i,
  input  logic [AW-1:0] in_addr_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [2:0]    out_kind_o,
  output logic [RW-1:0] out_reg_o,
  output logic [AW-1:0] out_addr_o,
  output logic [AW-1:0] out_src_o
);
  logic [NREG-1:0]         pend_q, nx_pend;
  logic                    fin_vld_q, nx_fin_vld;
  ev_kind_e                fin_kind_q, nx_kind;
  logic [RW-1:0]           fin_reg_q;
  logic [AW-1:0]           fin_addr_q, fin_src_q, nx_src;

  logic [NREG-1:0]         tb_vld, tb_hit, clr_mask, reg_oh;
  logic [NREG-1:0][AW-1:0] tb_src;
  logic [RW-1:0]           fl_idx;
  logic                    fl_any, acc, fin_done, flush_pop, set_ld;
  ev_kind_e                in_kind;

  assign in_kind = ev_kind_e'(in_kind_i);
  assign reg_oh  = NREG'(1) << in_reg_i;

  uit_pick_low #(.N(NREG)) u_pick (
    .mask_i (pend_q),
    .idx_o  (fl_idx),
    .any_o  (fl_any)
  );

  assign out_valid_o = fl_any || fin_vld_q;
  assign out_kind_o  = fl_any ? EV_LD : fin_kind_q;
  assign out_reg_o   = fl_any ? fl_idx : fin_reg_q;
  assign out_addr_o  = fl_any ? tb_src[fl_idx] : fin_addr_q;
  assign out_src_o   = fl_any ? '0 : fin_src_q;

  assign in_ready_o = !fl_any && (!fin_vld_q || out_ready_i);
  assign acc        = in_valid_i && in_ready_o;
  assign fin_done   = !fl_any && fin_vld_q && out_ready_i;
  assign flush_pop  = fl_any && out_ready_i;
  assign clr_mask   = flush_pop ? (NREG'(1) << fl_idx) : '0;
  assign set_ld     = acc && track_en_i && (in_kind == EV_LD);

  uit_table #(.NREG(NREG), .AW(AW)) u_tab (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_all_i    (!track_en_i && !fl_any),
    .clr_mask_i   (clr_mask),
    .set_i        (set_ld),
    .set_idx_i    (in_reg_i),
    .set_addr_i   (in_addr_i),
    .probe_addr_i (in_addr_i),
    .vld_o        (tb_vld),
    .src_o        (tb_src),
    .hit_o        (tb_hit)
  );

  // job planned for the accepted event: deferred loads first, then the final event
  always_comb begin
    nx_pend    = '0;
    nx_fin_vld = 1'b1;
    nx_kind    = in_kind;
    nx_src     = '0;
    if (track_en_i) begin
      unique case (in_kind)
        EV_LD:  nx_fin_vld = 1'b0;
        EV_ST: begin
          nx_pend = tb_hit & ~reg_oh;
          if (tb_vld[in_reg_i]) begin
            nx_kind = EV_MM;
            nx_src  = tb_src[in_reg_i];
          end
        end
        EV_IMM: nx_pend = tb_hit;
        EV_OPM: nx_pend = tb_vld & reg_oh;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      fin_vld_q  <= 1'b0;
      fin_kind_q <= EV_OTHER;
      fin_reg_q  <= '0;
      fin_addr_q <= '0;
      fin_src_q  <= '0;
    end else begin
      if (acc) begin
        pend_q     <= nx_pend;
        fin_vld_q  <= nx_fin_vld;
        fin_kind_q <= nx_kind;
        fin_reg_q  <= in_reg_i;
        fin_addr_q <= in_addr_i;
        fin_src_q  <= nx_src;
      end else begin
        if (fin_done)  fin_vld_q <= 1'b0;
        if (flush_pop) pend_q    <= pend_q & ~clr_mask;
      end
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_kind_o)
      && $stable(out_reg_o) && $stable(out_addr_o) && $stable(out_src_o));

  a_r9_stall_on_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_kind_o == EV_LD && track_en_i && fin_vld_q && fl_any |-> !in_ready_o);

  a_r2_load_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && track_en_i && in_kind_i == EV_LD |=> !out_valid_o);

  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && !track_en_i |=> out_valid_o
      && out_kind_o == $past(in_kind_i) && out_addr_o == $past(in_addr_i) && out_src_o == '0);

  a_r4_op_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && track_en_i && in_kind_i == EV_OPM && tb_vld[in_reg_i]
      |=> out_valid_o && out_kind_o == EV_LD && out_reg_o == $past(in_reg_i));
endmodule

// File: tb/inherit_track_test.sv
module inherit_track_test;
  localparam int NREG = 8;
  localparam int AW   = 32;
  localparam int RW   = 3;

  typedef struct {
    logic [2:0]    kind;
    logic [RW-1:0] rg;
    logic [AW-1:0] addr;
    logic [AW-1:0] src;
    int            tag;
  } item_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, track_en_i = 1'b0;
  logic in_valid_i = 1'b0, out_ready_i = 1'b1;
  logic [2:0] in_kind_i = '0;
  logic [RW-1:0] in_reg_i = '0;
  logic [AW-1:0] in_addr_i = '0;
  logic in_ready_o, out_valid_o;
  logic [2:0] out_kind_o;
  logic [RW-1:0] out_reg_o;
  logic [AW-1:0] out_addr_o, out_src_o;

  int checks = 0, fails = 0;
  bit rand_ready = 0;
  item_t expq[$];
  logic          mv [NREG];
  logic [AW-1:0] ms [NREG];

  always #10 clk_i = ~clk_i;

  inherit_track #(.NREG(NREG), .AW(AW)) uut (.*);

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] k, logic [RW-1:0] r, logic [AW-1:0] a, logic [AW-1:0] s, int tag);
    item_t it;
    it.kind = k; it.rg = r; it.addr = a; it.src = s; it.tag = tag;
    expq.push_back(it);
  endtask

  // reference model of the requirements, updated when an event is accepted
  task automatic model(logic [2:0] k, logic [RW-1:0] r, logic [AW-1:0] a);
    if (!track_en_i) begin
      push(k, r, a, 0, 7);                          // R7
      for (int i = 0; i < NREG; i++) mv[i] = 0;
    end else if (k == 3'd1) begin
      mv[r] = 1; ms[r] = a;                         // R2, R10
    end else if (k == 3'd2 || k == 3'd3) begin
      for (int i = 0; i < NREG; i++)
        if (mv[i] && ms[i] == a && !(k == 3'd2 && i == int'(r))) begin
          push(3'd1, RW'(i), ms[i], 0, 6);          // R6
          mv[i] = 0;
        end
      if (k == 3'd2 && mv[r]) push(3'd5, r, a, ms[r], 3);   // R3
      else push(k, r, a, 0, (k == 3'd2) ? 3 : 5);          // R3, R5
    end else if (k == 3'd4) begin
      if (mv[r]) begin push(3'd1, r, ms[r], 0, 4); mv[r] = 0; end  // R4
      push(k, r, a, 0, 4);
    end else begin
      push(k, r, a, 0, 8);                          // R8
    end
  endtask

  task automatic send(logic [2:0] k, logic [RW-1:0] r, logic [AW-1:0] a);
    @(posedge clk_i); #2;
    in_valid_i = 1; in_kind_i = k; in_reg_i = r; in_addr_i = a;
    forever begin
      @(negedge clk_i);
      if (in_ready_o) begin
        model(k, r, a);
        @(posedge clk_i); #2;
        in_valid_i = 0;
        break;
      end
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 200 && (expq.size() != 0 || out_valid_o); n++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(expq.size() == 0, "R2", "pending expected events", expq.size(), 0);
  endtask

  // output ready driver
  always @(posedge clk_i) begin
    #2 out_ready_i = rand_ready ? 1'($urandom % 2) : 1'b1;
  end

  // monitor / scoreboard
  logic          hold_v = 0;
  logic [2:0]    hold_k;
  logic [AW-1:0] hold_a, hold_s;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (hold_v) begin  // R9 stability under backpressure
        chk(out_valid_o && out_kind_o == hold_k && out_addr_o == hold_a && out_src_o == hold_s,
            "R9", "held event changed", out_addr_o, hold_a);
      end
      hold_v = out_valid_o && !out_ready_i;
      hold_k = out_kind_o; hold_a = out_addr_o; hold_s = out_src_o;
      if (out_valid_o && out_ready_i) begin
        if (expq.size() == 0) begin
          chk(0, "R2", "unexpected output kind", out_kind_o, 0);
        end else begin
          item_t e;
          string rq;
          e = expq.pop_front();
          rq = $sformatf("R%0d", e.tag);
          chk(out_kind_o == e.kind, rq, "kind", out_kind_o, e.kind);
          chk(out_reg_o == e.rg, rq, "reg", out_reg_o, e.rg);
          chk(out_addr_o == e.addr, rq, "addr", out_addr_o, e.addr);
          chk(out_src_o == e.src, rq, "src", out_src_o, e.src);
        end
      end
    end
  end

  task automatic run_tests();
    for (int i = 0; i < NREG; i++) begin mv[i] = 0; ms[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o, "R1", "reset out_valid", out_valid_o, 0);
    chk(in_ready_o, "R1", "reset in_ready", in_ready_o, 1);
    @(posedge clk_i); #2 rst_ni = 1; track_en_i = 1;

    send(3'd2, 3'd0, 32'h50); drain();                          // R1 empty table: plain store
    send(3'd1, 3'd1, 32'h100); drain();                         // R2 silent load
    send(3'd2, 3'd1, 32'h200); send(3'd2, 3'd2, 32'h300); drain(); // R3
    send(3'd1, 3'd2, 32'h400); send(3'd4, 3'd2, 32'h500);
    send(3'd2, 3'd2, 32'h600); drain();                         // R4 entry cleared
    send(3'd3, 3'd4, 32'h700); drain();                         // R5
    send(3'd1, 3'd0, 32'hA0); send(3'd1, 3'd5, 32'hA0);
    send(3'd1, 3'd3, 32'hA0); send(3'd1, 3'd6, 32'hB0);
    send(3'd3, 3'd7, 32'hA0); send(3'd2, 3'd3, 32'hA0); drain(); // R6 ascending flush
    send(3'd1, 3'd4, 32'hC0); send(3'd1, 3'd7, 32'hC0);
    send(3'd2, 3'd4, 32'hC0); drain();                          // R6 self excluded
    send(3'd1, 3'd1, 32'h111); send(3'd1, 3'd1, 32'h222);
    send(3'd2, 3'd1, 32'h333); drain();                         // R10
    send(3'd0, 3'd1, 32'h222); send(3'd6, 3'd1, 32'h9);
    send(3'd2, 3'd1, 32'h444); drain();                         // R8 table untouched
    @(posedge clk_i); #2 track_en_i = 0;
    send(3'd1, 3'd2, 32'h900); send(3'd2, 3'd1, 32'h910);
    send(3'd4, 3'd6, 32'h920); drain();                         // R7
    @(posedge clk_i); #2 track_en_i = 1;
    send(3'd2, 3'd1, 32'h930); send(3'd3, 3'd0, 32'hB0); drain(); // R7 table emptied
    rand_ready = 1;                                             // R9 backpressure phase
    send(3'd1, 3'd0, 32'h10); send(3'd1, 3'd2, 32'h10); send(3'd1, 3'd5, 32'h10);
    send(3'd2, 3'd7, 32'h10);
    for (int n = 0; n < 400; n++)
      send(3'($urandom % 5), RW'($urandom), AW'(32'h10 * (1 + $urandom % 3)));
    drain();
    rand_ready = 0;
    repeat (4) @(negedge clk_i);
    chk(!out_valid_o, "R9", "idle after drain", out_valid_o, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog expired: actual hung expected done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule